// File: doc/BRIEF.md
# Linear Sub-Block SAD Engine

This block is the arithmetic core of an exhaustive block-matching search over one 16x16 macroblock. A row of processing elements works side by side. Each element owns one candidate displacement. The pixels of the current block enter one at a time, and every element receives the same current pixel. Each element also gets its own reference pixel on a separate lane of a wide input. Every element forms the absolute difference between the two pixels and adds it to a running sum.

Each element does not keep one total for the whole macroblock. Instead it holds one sum for each 4x4 sub-block. The write position in the macroblock picks which sum receives each difference. When a pass ends, all sixteen partial sums of every element appear together on a flat output bus. Logic further down the chain can then add them into any larger partition without running the match again.

The host pulses a start input and then streams exactly 256 valid pixels. It may leave idle gaps between them. The block reports the end of the pass with a one-cycle pulse. Covering a full search window takes repeated passes, each with a new set of candidates on the reference lanes.

Top module: `sad_array_1d`

## Requirements
- R1: While reset is held, and after it is released, `busy_o` and `done_o` are 0 and every field of `sad_o` is 0.
- R2: A cycle with `start_i` high clears every field of `sad_o` to 0 and raises `busy_o` in the next cycle. It also discards every pixel still in the pipeline. A pixel presented in the same cycle as `start_i` is not accepted.
- R3: Pixels are accepted in raster order: position p sits at row p/16, column p%16. Each accepted pixel adds |cur − ref_k| to field s of element k, where s = (row/4)*4 + (col/4). Field s of element k occupies `sad_o[(k*16+s)*12 +: 12]`.
- R4: A cycle with `cur_vld_i` low changes neither the position counter nor any sum, whatever values sit on the pixel inputs.
- R5: When no pass is active, valid pixels are ignored. The sums stay unchanged and `done_o` stays low.
- R6: `busy_o` falls in the cycle after the 256th pixel is accepted. `done_o` is high for exactly one cycle, LAT = 2 + REG_ABS cycles after the cycle in which the 256th pixel was presented (LAT = 3 by default). `done_o` is never high while `busy_o` is high.
- R7: From the cycle `done_o` is high until the next `start_i`, `sad_o` holds its value.
- R8: A `start_i` during an active pass abandons that pass. The sums restart from zero, and the next 256 accepted pixels form a fresh pass.
- R9: The sums do not wrap. A sub-block in which all 16 differences are 255 reads 4080.
- R10: Reference lane k is `ref_pix_i[k*8 +: 8]`. Its differences reach only element k's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pass and clear all sums |
| cur_vld_i | input | 1 | Current and reference pixels are valid this cycle |
| cur_pix_i | input | PIX_W (8) | Current-block pixel, sent to every element |
| ref_pix_i | input | NUM_PE*PIX_W (128) | One reference pixel per element |
| busy_o | output | 1 | A pass is accepting pixels |
| done_o | output | 1 | One-cycle pulse: all sums are final |
| sad_o | output | NUM_PE*NUM_SUB*ACC_W (3072) | Partial sums, element-major then sub-block |

## Verification
The bound checker tests, on every cycle, only the control timing that can be seen at the ports:
- a start clears the sums and raises the busy flag one cycle later;
- the completion pulse is exactly one cycle long and never overlaps busy;
- the sums stay frozen from completion until the next start.

The remaining checks need a model of the stream, so only the bench scenarios can show them. These are the arithmetic itself, the routing of each pixel to the right sub-block and lane, the ignoring of idle and out-of-pass pixels, the saturated extreme, and a restart in the middle of a pass. For those, every field is compared against sums that the bench builds itself.

// File: rtl/sad_pkg.sv
package sad_pkg;
   typedef enum logic [0:0] {
      RUN_IDLE   = 1'b0,
      RUN_ACTIVE = 1'b1
   } run_e;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
   import sad_pkg::*;
#(
   parameter int BLK_W = 16,
   parameter int SUB_W = 4,
   localparam int LOG_BLK = $clog2(BLK_W),
   localparam int LOG_SUB = $clog2(SUB_W),
   localparam int CNT_W   = 2 * LOG_BLK,
   localparam int IDX_W   = 2 * (LOG_BLK - LOG_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             vld_i,
   output logic             busy_o,
   output logic             take_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o
);
   localparam int NPIX = BLK_W * BLK_W;
   localparam int SEG  = LOG_BLK - LOG_SUB;

   run_e             st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= RUN_IDLE;
         cnt <= '0;
      end else if (start_i) begin
         st  <= RUN_ACTIVE;
         cnt <= '0;
      end else if (take_o) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(NPIX - 1)) st <= RUN_IDLE;
      end
   end

   always_comb begin
      busy_o = (st == RUN_ACTIVE);
      take_o = busy_o && vld_i && !start_i;
      last_o = take_o && (cnt == CNT_W'(NPIX - 1));
      // upper bits of the row index, then upper bits of the column index
      idx_o  = {cnt[CNT_W-1 -: SEG], cnt[LOG_BLK-1 -: SEG]};
   end
endmodule

// File: rtl/sad_pe.sv
module sad_pe #(
   parameter int PIX_W   = 8,
   parameter int ACC_W   = 12,
   parameter int NUM_SUB = 16,
   parameter int IDX_W   = 4,
   parameter bit REG_ABS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     vld_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [PIX_W-1:0]         cur_i,
   input  logic [PIX_W-1:0]         ref_i,
   output logic [NUM_SUB*ACC_W-1:0] sad_o
);
   logic [PIX_W-1:0] ad;
   logic             a_vld;
   logic [IDX_W-1:0] a_idx;
   logic [PIX_W-1:0] a_val;
   logic [ACC_W-1:0] acc [NUM_SUB];

   always_comb ad = (cur_i >= ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);

   generate
      if (REG_ABS) begin : g_abs_reg
         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
               a_vld <= 1'b0;
               a_idx <= '0;
               a_val <= '0;
            end else begin
               a_vld <= vld_i;
               a_idx <= idx_i;
               a_val <= ad;
            end
         end
      end else begin : g_abs_comb
         always_comb begin
            a_vld = vld_i;
            a_idx = idx_i;
            a_val = ad;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         for (int s = 0; s < NUM_SUB; s++) acc[s] <= '0;
      end else if (a_vld) begin
         acc[a_idx] <= acc[a_idx] + ACC_W'(a_val);
      end
   end

   generate
      for (genvar s = 0; s < NUM_SUB; s++) begin : g_out
         assign sad_o[s*ACC_W +: ACC_W] = acc[s];
      end
   endgenerate
endmodule

// File: rtl/sad_array_1d.sv
module sad_array_1d
   import sad_pkg::*;
#(
   parameter int NUM_PE  = 16,
   parameter int PIX_W   = 8,
   parameter int BLK_W   = 16,
   parameter int SUB_W   = 4,
   parameter bit REG_ABS = 1'b1,
   parameter int ACC_W   = PIX_W + $clog2(SUB_W * SUB_W),
   localparam int NUM_SUB = (BLK_W / SUB_W) * (BLK_W / SUB_W),
   localparam int IDX_W   = 2 * ($clog2(BLK_W) - $clog2(SUB_W)),
   localparam int SAD_W   = NUM_PE * NUM_SUB * ACC_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    cur_vld_i,
   input  logic [PIX_W-1:0]        cur_pix_i,
   input  logic [NUM_PE*PIX_W-1:0] ref_pix_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic [SAD_W-1:0]        sad_o
);
   generate
      if (NUM_PE < 1) begin : g_bad_pe
         $error("NUM_PE must be at least 1");
      end
      if (!is_pow2(BLK_W) || !is_pow2(SUB_W)) begin : g_bad_pow2
         $error("BLK_W and SUB_W must be powers of two");
      end
      if (SUB_W >= BLK_W) begin : g_bad_sub
         $error("SUB_W must be smaller than BLK_W");
      end
      if (ACC_W < PIX_W + $clog2(SUB_W * SUB_W)) begin : g_bad_acc
         $error("ACC_W too narrow for a full sub-block sum");
      end
   endgenerate

   logic             take, last;
   logic [IDX_W-1:0] idx;

   sad_ctrl #(.BLK_W(BLK_W), .SUB_W(SUB_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .vld_i  (cur_vld_i),
      .busy_o (busy_o),
      .take_o (take),
      .last_o (last),
      .idx_o  (idx)
   );

   // input stage: retime the broadcast and lane pixels
   logic                    s1_vld, s1_last;
   logic [IDX_W-1:0]        s1_idx;
   logic [PIX_W-1:0]        s1_cur;
   logic [NUM_PE*PIX_W-1:0] s1_ref;

   always_ff @(posedge clk) begin
      if (!rst_n || start_i) begin
         s1_vld  <= 1'b0;
         s1_last <= 1'b0;
         s1_idx  <= '0;
         s1_cur  <= '0;
         s1_ref  <= '0;
      end else begin
         s1_vld  <= take;
         s1_last <= last;
         s1_idx  <= idx;
         s1_cur  <= cur_pix_i;
         s1_ref  <= ref_pix_i;
      end
   end

   generate
      for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
         sad_pe #(
            .PIX_W  (PIX_W),
            .ACC_W  (ACC_W),
            .NUM_SUB(NUM_SUB),
            .IDX_W  (IDX_W),
            .REG_ABS(REG_ABS)
         ) u_pe (
            .clk  (clk),
            .rst_n(rst_n),
            .clr_i(start_i),
            .vld_i(s1_vld),
            .idx_i(s1_idx),
            .cur_i(s1_cur),
            .ref_i(s1_ref[k*PIX_W +: PIX_W]),
            .sad_o(sad_o[k*NUM_SUB*ACC_W +: NUM_SUB*ACC_W])
         );
      end
   endgenerate

   // carry the end-of-pass marker down to the accumulate stage
   logic acc_last;
   generate
      if (REG_ABS) begin : g_last_reg
         logic s2_last;
         always_ff @(posedge clk) begin
            if (!rst_n || start_i) s2_last <= 1'b0;
            else                   s2_last <= s1_last;
         end
         assign acc_last = s2_last;
      end else begin : g_last_comb
         assign acc_last = s1_last;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || start_i) done_o <= 1'b0;
      else                   done_o <= acc_last;
   end
endmodule

// File: rtl/sad_array_1d_chk.sv
module sad_array_1d_chk #(
   parameter int SAD_W = 3072
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [SAD_W-1:0] sad_o
);
   logic settled;

   always_ff @(posedge clk) begin
      if (!rst_n)       settled <= 1'b1;
      else if (start_i) settled <= 1'b0;
      else if (done_o)  settled <= 1'b1;
   end

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (sad_o == '0) && busy_o); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R6
   AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && !start_i) |=> $stable(sad_o)); // R7
endmodule

bind sad_array_1d sad_array_1d_chk #(.SAD_W(SAD_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .sad_o  (sad_o)
);

// File: tb/tb_sad_array_1d.sv
`timescale 1ns/1ps
module tb_sad_array_1d;
   localparam int NUM_PE  = 16;
   localparam int PIX_W   = 8;
   localparam int BLK_W   = 16;
   localparam int SUB_W   = 4;
   localparam int ACC_W   = 12;
   localparam int NUM_SUB = 16;
   localparam int NPIX    = 256;
   localparam int LAT     = 3;
   localparam int SAD_W   = NUM_PE * NUM_SUB * ACC_W;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    start_i = 1'b0;
   logic                    cur_vld_i = 1'b0;
   logic [PIX_W-1:0]        cur_pix_i = '0;
   logic [NUM_PE*PIX_W-1:0] ref_pix_i = '0;
   logic                    busy_o, done_o;
   logic [SAD_W-1:0]        sad_o;

   int checks = 0;
   int errors = 0;
   int exp_sad [NUM_PE][NUM_SUB];
   int pos = 0;
   bit in_pass = 0;

   always #4 clk = ~clk;

   sad_array_1d dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_vld_i(cur_vld_i),
      .cur_pix_i(cur_pix_i), .ref_pix_i(ref_pix_i),
      .busy_o(busy_o), .done_o(done_o), .sad_o(sad_o)
   );

   function automatic int sub_of(int p);
      return ((p / BLK_W) / SUB_W) * (BLK_W / SUB_W) + (p % BLK_W) / SUB_W;
   endfunction

   function automatic logic [NUM_PE*PIX_W-1:0] rnd_refs();
      logic [NUM_PE*PIX_W-1:0] r;
      for (int k = 0; k < NUM_PE; k++) r[k*PIX_W +: PIX_W] = PIX_W'($urandom);
      return r;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      for (int k = 0; k < NUM_PE; k++)
         for (int s = 0; s < NUM_SUB; s++)
            chk(req, int'(sad_o[(k*NUM_SUB+s)*ACC_W +: ACC_W]), exp_sad[k][s]);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      cur_vld_i = 1'b1;              // same-cycle pixel must be dropped (R2)
      cur_pix_i = 8'd200;
      ref_pix_i = rnd_refs();
      @(negedge clk);
      start_i = 1'b0;
      cur_vld_i = 1'b0;
      for (int k = 0; k < NUM_PE; k++)
         for (int s = 0; s < NUM_SUB; s++) exp_sad[k][s] = 0;
      pos = 0;
      in_pass = 1;
      chk("R2 busy", int'(busy_o), 1);
      check_all("R2 clear");
   endtask

   // drive at a falling edge; the design samples at the next rising edge
   task automatic feed(bit v, logic [PIX_W-1:0] c, logic [NUM_PE*PIX_W-1:0] r);
      @(negedge clk);
      cur_vld_i = v;
      cur_pix_i = c;
      ref_pix_i = r;
      if (v && in_pass) begin
         for (int k = 0; k < NUM_PE; k++) begin
            int a = int'(c);
            int b = int'(r[k*PIX_W +: PIX_W]);
            exp_sad[k][sub_of(pos)] += (a > b) ? a - b : b - a;
         end
         pos++;
         if (pos == NPIX) in_pass = 0;
      end
      @(posedge clk);
   endtask

   task automatic finish_pass(string req);
      for (int i = 1; i <= LAT + 1; i++) begin
         @(negedge clk);
         cur_vld_i = 1'b0;
         if (i == 1) chk("R6 busy falls", int'(busy_o), 0);
         chk("R6 done timing", int'(done_o), (i == LAT) ? 1 : 0);
      end
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < NUM_PE; k++)
         for (int s = 0; s < NUM_SUB; s++) exp_sad[k][s] = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 done", int'(done_o), 0);
      check_all("R1 sums");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // continuous random pass: R3, R10
      pulse_start();
      while (in_pass) feed(1'b1, PIX_W'($urandom), rnd_refs());
      finish_pass("R3 R10 random pass");

      // random idle gaps with noise on the data inputs: R4
      pulse_start();
      while (in_pass) begin
         if ($urandom_range(2) == 0) feed(1'b0, PIX_W'($urandom), rnd_refs());
         else                        feed(1'b1, PIX_W'($urandom), rnd_refs());
      end
      finish_pass("R4 gapped pass");

      // pixels outside a pass: R5, R7
      for (int i = 0; i < 30; i++) begin
         feed(1'b1, PIX_W'($urandom), rnd_refs());
         @(negedge clk);
         chk("R5 no done", int'(done_o), 0);
      end
      cur_vld_i = 1'b0;
      @(negedge clk);
      check_all("R5 R7 held");

      // extreme differences: R9, lane separation R10
      pulse_start();
      while (in_pass) begin
         logic [NUM_PE*PIX_W-1:0] r;
         for (int k = 0; k < NUM_PE; k++) r[k*PIX_W +: PIX_W] = PIX_W'(k);
         feed(1'b1, 8'd255, r);
      end
      finish_pass("R9 R10 extreme");
      chk("R9 max", int'(sad_o[0 +: ACC_W]), 4080);
      chk("R10 lane15", int'(sad_o[(15*NUM_SUB+5)*ACC_W +: ACC_W]), 16*240);

      // restart in the middle of a pass: R8
      pulse_start();
      for (int i = 0; i < 100; i++) feed(1'b1, PIX_W'($urandom), rnd_refs());
      pulse_start();
      while (in_pass) feed(1'b1, PIX_W'($urandom), rnd_refs());
      finish_pass("R8 restart");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule